// File: doc/BRIEF.md
# Fetch Access Benchmark Counters

This block keeps two free-running 32-bit tallies of accesses to a nonvolatile memory array. One counts instruction fetches and the other counts data fetches. Each is advanced by a one-cycle strobe from the bus side. Software reads and writes both tallies, and a set of control registers, through a small register port. The write is synchronous and the read is combinational.

One compare unit watches the tally that software selects. When that tally steps into equality with a programmed compare value, the unit sets a sticky event flag. Software clears the flag by writing one to a clear register. The level interrupt output is high while the flag is set and the enable bit is on.

The block is used for power profiling. Software presets a tally and a compare value, runs code, and takes an interrupt after a chosen number of fetches.

Top module: `fetch_bench_counters`

## Requirements
- R1: After reset both counters, the compare value, the control register and the event flag are zero, and irqOut is low.
- R2: The instruction counter (address 0) increases by exactly one at each clock edge where fetchInst is high.
- R3: The data counter (address 1) increases by exactly one at each clock edge where fetchData is high.
- R4: A register write to address 0 or 1 loads regWrData into that counter; a fetch strobe in the same cycle is lost.
- R5: A counter at 0xFFFFFFFF that sees a fetch strobe becomes 0; it does not saturate.
- R6: Register map: address 2 is the compare value; address 3 is control, where bit 0 selects the watched counter (0 instruction, 1 data) and bit 1 is the interrupt enable; address 4 reads the flag in bit 0 and ignores writes; a write to address 5 with bit 0 set clears the flag; addresses 5 to 7 read as zero.
- R7: The flag is set at the clock edge after the selected counter first becomes equal to the compare value. Equality is entered through a count, a counter write, a compare write or a source change. Equality that continues, or that already held when reset was released, does not set the flag.
- R8: Once set, the flag stays set until a clear write.
- R9: If a clear write falls in the same cycle as a new match, the flag stays set.
- R10: irqOut is high exactly when the flag and the enable bit are both set. The flag is set even while the enable bit is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchInst | input | 1 | One-cycle instruction fetch strobe |
| fetchData | input | 1 | One-cycle data fetch strobe |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Level interrupt, flag AND enable |

## Verification
A wrong counter value appears on the read port as soon as the strobe edge has passed. A wrong equality history shows up one edge later, in two ways: as a flag that never rises, or as a flag that rises again after a clear while the counter is parked on the compare value. Both are visible at status address 4 and on irqOut within two cycles of the stimulus. The bench also checks the cases where the flag must survive a clear and where a strobe must be lost.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  localparam int NUM_CNT = 2;

  typedef enum logic [2:0] {
    ADDR_INST = 3'd0,
    ADDR_DATA = 3'd1,
    ADDR_CMP  = 3'd2,
    ADDR_CTRL = 3'd3,
    ADDR_STAT = 3'd4,
    ADDR_CLR  = 3'd5
  } addr_e;

  typedef struct packed {
    logic [NUM_CNT-1:0] wrCnt;
    logic               wrCmp;
    logic               wrCtrl;
    logic               clrFlag;
  } strobe_t;

endpackage

// File: rtl/fbc_ctrl.sv
module fbc_ctrl
  import fbc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  input  logic [CNT_W-1:0] instCnt,
  input  logic [CNT_W-1:0] dataCnt,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             srcSel,
  input  logic             irqEn,
  input  logic             flag,
  output strobe_t          strb,
  output logic [CNT_W-1:0] regRdData
);

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_INST: strb.wrCnt[0] = 1'b1;
        ADDR_DATA: strb.wrCnt[1] = 1'b1;
        ADDR_CMP:  strb.wrCmp    = 1'b1;
        ADDR_CTRL: strb.wrCtrl   = 1'b1;
        ADDR_CLR:  strb.clrFlag  = regWrData[0];
        default:   strb = '0;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_INST: regRdData = instCnt;
      ADDR_DATA: regRdData = dataCnt;
      ADDR_CMP:  regRdData = cmpVal;
      ADDR_CTRL: regRdData[1:0] = {irqEn, srcSel};
      ADDR_STAT: regRdData[0] = flag;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/fbc_datapath.sv
module fbc_datapath
  import fbc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_CNT-1:0] fetch,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] wrValue,
  output logic [CNT_W-1:0] instCnt,
  output logic [CNT_W-1:0] dataCnt,
  output logic [CNT_W-1:0] cmpVal,
  output logic             srcSel,
  output logic             irqEn,
  output logic             flag,
  output logic             irqOut
);

  logic [CNT_W-1:0] cnt [NUM_CNT];
  logic             eqPrev;
  logic             eqNow;
  logic             matchPulse;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                 cnt[i] <= '0;
      else if (strb.wrCnt[i])  cnt[i] <= wrValue;
      else if (fetch[i])       cnt[i] <= cnt[i] + 1'b1;
    end

    // R4
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
      strb.wrCnt[i] |=> cnt[i] == $past(wrValue));

    // R2 R3 R5
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      fetch[i] && !strb.wrCnt[i] |=> cnt[i] == $past(cnt[i]) + 1'b1);
  end

  assign instCnt = cnt[0];
  assign dataCnt = cnt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpVal <= '0;
      srcSel <= 1'b0;
      irqEn  <= 1'b0;
    end else begin
      if (strb.wrCmp)  cmpVal <= wrValue;
      if (strb.wrCtrl) {irqEn, srcSel} <= wrValue[1:0];
    end
  end

  assign eqNow      = (srcSel ? cnt[1] : cnt[0]) == cmpVal;
  assign matchPulse = eqNow && !eqPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      eqPrev <= 1'b1;
      flag   <= 1'b0;
    end else begin
      eqPrev <= eqNow;
      if (matchPulse)        flag <= 1'b1;
      else if (strb.clrFlag) flag <= 1'b0;
    end
  end

  assign irqOut = flag && irqEn;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag && !strb.clrFlag |=> flag);

  // R9
  set_over_clr_chk: assert property (@(posedge clk) disable iff (rst)
    matchPulse |=> flag);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |-> !irqOut);

endmodule

// File: rtl/fetch_bench_counters.sv
module fetch_bench_counters
  import fbc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetchInst,
  input  logic             fetchData,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             irqOut
);

  strobe_t          strb;
  logic [CNT_W-1:0] instCnt;
  logic [CNT_W-1:0] dataCnt;
  logic [CNT_W-1:0] cmpVal;
  logic             srcSel;
  logic             irqEn;
  logic             flag;

  fbc_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .instCnt   (instCnt),
    .dataCnt   (dataCnt),
    .cmpVal    (cmpVal),
    .srcSel    (srcSel),
    .irqEn     (irqEn),
    .flag      (flag),
    .strb      (strb),
    .regRdData (regRdData)
  );

  fbc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .fetch   ({fetchData, fetchInst}),
    .strb    (strb),
    .wrValue (regWrData),
    .instCnt (instCnt),
    .dataCnt (dataCnt),
    .cmpVal  (cmpVal),
    .srcSel  (srcSel),
    .irqEn   (irqEn),
    .flag    (flag),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/fetch_bench_counters_tb.sv
module fetch_bench_counters_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetchInst, fetchData, regWrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        irqOut;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fetch_bench_counters dut_i (
    .clk(clk), .rst(rst), .fetchInst(fetchInst), .fetchData(fetchData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic        fi;
    logic        fd;
    logic [2:0]  rdAddr;
    logic [31:0] expRd;
    logic        expIrq;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'd0,          1'b0, 1'b0, 3'd0, 32'd0,          1'b0, " R1"},
    '{1'b0, 3'd0, 32'd0,          1'b1, 1'b0, 3'd0, 32'd1,          1'b0, " R2"},
    '{1'b0, 3'd0, 32'd0,          1'b1, 1'b1, 3'd1, 32'd1,          1'b0, " R3"},
    '{1'b1, 3'd2, 32'd3,          1'b0, 1'b0, 3'd2, 32'd3,          1'b0, " R6"},
    '{1'b1, 3'd3, 32'd2,          1'b0, 1'b0, 3'd3, 32'd2,          1'b0, " R6"},
    '{1'b0, 3'd0, 32'd0,          1'b1, 1'b0, 3'd4, 32'd1,          1'b1, " R7"},
    '{1'b1, 3'd5, 32'd1,          1'b0, 1'b0, 3'd4, 32'd0,          1'b0, " R7"},
    '{1'b1, 3'd1, 32'd5,          1'b0, 1'b1, 3'd1, 32'd5,          1'b0, " R4"},
    '{1'b1, 3'd3, 32'd3,          1'b0, 1'b0, 3'd4, 32'd0,          1'b0, " R6"},
    '{1'b1, 3'd2, 32'd6,          1'b0, 1'b0, 3'd4, 32'd0,          1'b0, " R7"},
    '{1'b0, 3'd0, 32'd0,          1'b0, 1'b1, 3'd4, 32'd1,          1'b1, " R7"},
    '{1'b1, 3'd5, 32'd1,          1'b0, 1'b1, 3'd4, 32'd0,          1'b0, " R8"},
    '{1'b1, 3'd0, 32'hFFFF_FFFF,  1'b0, 1'b0, 3'd0, 32'hFFFF_FFFF,  1'b0, " R4"},
    '{1'b0, 3'd0, 32'd0,          1'b1, 1'b0, 3'd0, 32'd0,          1'b0, " R5"},
    '{1'b1, 3'd3, 32'd1,          1'b0, 1'b0, 3'd3, 32'd1,          1'b0, " R6"},
    '{1'b1, 3'd2, 32'd8,          1'b0, 1'b1, 3'd4, 32'd1,          1'b0, "R10"},
    '{1'b1, 3'd3, 32'd3,          1'b0, 1'b0, 3'd4, 32'd1,          1'b1, "R10"},
    '{1'b1, 3'd5, 32'd1,          1'b0, 1'b0, 3'd4, 32'd0,          1'b0, " R8"},
    '{1'b1, 3'd2, 32'd9,          1'b0, 1'b0, 3'd6, 32'd0,          1'b0, " R6"}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input logic [23:0] tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    regWrEn = 1'b0; fetchInst = 1'b0; fetchData = 1'b0;
  endtask

  initial begin
    rst = 1'b1; idle(); regAddr = 3'd0; regWrData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      regWrEn = VECS[k].we; regAddr = VECS[k].addr; regWrData = VECS[k].wdata;
      fetchInst = VECS[k].fi; fetchData = VECS[k].fd;
      @(negedge clk);
      idle(); regAddr = VECS[k].rdAddr;
      @(negedge clk);
      check(regRdData, VECS[k].expRd, VECS[k].tag, "read");
      check({31'd0, irqOut}, {31'd0, VECS[k].expIrq}, VECS[k].tag, "irq");
    end

    // R9: clear in the same cycle as a new match (data counter 8 -> 9, compare 9)
    fetchData = 1'b1;
    @(negedge clk);
    idle(); regWrEn = 1'b1; regAddr = 3'd5; regWrData = 32'd1;
    @(negedge clk);
    idle(); regAddr = 3'd4;
    #1 check(regRdData, 32'd1, " R9", "flag after clear+match");
    check({31'd0, irqOut}, 32'd1, " R9", "irq after clear+match");

    // R7: counter parked on compare value does not set flag again
    regWrEn = 1'b1; regAddr = 3'd5; regWrData = 32'd1;
    @(negedge clk);
    idle(); regAddr = 3'd4;
    repeat (3) @(negedge clk);
    check(regRdData, 32'd0, " R7", "no retrigger while equal");

    // R6: write to status is ignored
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 32'hFFFF_FFFF;
    @(negedge clk);
    idle();
    @(negedge clk);
    check(regRdData, 32'd0, " R6", "status write ignored");

    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; regAddr = 3'd1;
    #1 check(regRdData, 32'd0, " R1", "data counter after reset");
    regAddr = 3'd2;
    #1 check(regRdData, 32'd0, " R1", "compare after reset");
    regAddr = 3'd3;
    #1 check(regRdData, 32'd0, " R1", "control after reset");
    @(negedge clk);
    regAddr = 3'd4;
    #1 check(regRdData, 32'd0, " R1", "flag after reset");
    check({31'd0, irqOut}, 32'd0, " R1", "irq after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule